// File: doc/BRIEF.md
# Management Bus Command Sequencer

This block carries out one decoded management command at a time. It talks to a switch controller over an 8-bit bidirectional register bus with three control lines: an active-low strobe, a read/write select and a data/command select. A write command first loads the controller's data registers from a local byte buffer. It then writes the instruction byte into the command register. A read command writes the instruction first and then reads data registers back into the same buffer.

Every bus access is one strobe slot of four clocks: the strobe is low for two clocks and high for two. Direction, select and write data stay fixed for the whole slot. After each instruction write, the status register is read slot after slot until its bit 7 is high. There is no limit on how long this wait may last. A flag can ask for the same poll to run before the command starts. Data register accesses count up from register 0. The number of accesses is the requested count, limited to the number of registers.

The host loads write bytes through a buffer write port and presents the command with a one-cycle valid pulse while the block is ready. It then waits for the done pulse and reads the results through the buffer read port. The bus is split into an output byte, an output enable and an input byte. A pad ring or a bench joins these into the shared wires.

Top module: `mbs_seq`

## Requirements
- R1: After reset the block is ready and idle. It holds the strobe high, read/write high (1 = read), the output enable low and done low.
- R2: While a command runs, every strobe pulse lasts exactly 2 clocks low, and the strobe stays high for at least 2 clocks between pulses.
- R3: The bus output enable is high exactly when read/write is low. The bus is released whenever read/write is high.
- R4: A write command with count n performs n data-register writes (data/command select = 1) carrying buffer bytes 0..n-1 in that order. It then writes the instruction byte with data/command select = 0.
- R5: The number of data-register accesses is the command count limited to 13. A count of 0 performs no data access. Buffer entries at or above the access count are left unchanged by a read command.
- R6: After the instruction write, the block performs status reads (read/write = 1, data/command select = 0) until one returns bit 7 high. Bits 6..0 of the status byte are ignored. It issues no further write access before that read.
- R7: A read command with count n performs n data-register reads (read/write = 1, data/command select = 1) after the acknowledge. The byte read in the k-th access is stored in buffer entry k.
- R8: When the poll-first flag is set, status reads repeat until bit 7 is high before any data or instruction access. When the flag is clear, no status read precedes the first data or instruction access.
- R9: Read/write, data/command select and the driven data byte stay stable from the falling strobe edge until two clocks after the rising edge.
- R10: Done is a single-cycle pulse issued once the exchange completes, after which the block is ready again. A command valid pulse given while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request pulse, taken only while ready |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_read | input | 1 | 1 = read command, 0 = write command |
| cmd_poll_first | input | 1 | Poll the status register for readiness before starting |
| cmd_instr | input | 8 | Instruction byte for the controller's command register |
| cmd_count | input | 8 | Requested number of data registers |
| done | output | 1 | One-cycle completion pulse |
| buf_wr_en | input | 1 | Host write strobe for the byte buffer |
| buf_wr_addr | input | 4 | Host buffer write index |
| buf_wr_data | input | 8 | Host buffer write byte |
| buf_rd_addr | input | 4 | Host buffer read index |
| buf_rd_data | output | 8 | Host buffer read byte |
| bus_strb_n | output | 1 | Bus strobe, active low |
| bus_rnw | output | 1 | Bus direction, 1 = read |
| bus_dnc | output | 1 | Bus select, 1 = data registers, 0 = command/status |
| bus_dout | output | 8 | Byte driven onto the bus |
| bus_oe | output | 1 | Bus output enable |
| bus_din | input | 8 | Byte read from the bus |

## Verification
A wrong state register shows up on the bus at the next strobe slot. It appears as an access with the wrong direction or select, as a missing or extra data access, or as a write issued before the acknowledge. The bench records every slot at its rising strobe edge, so such an error is caught within four clocks of the bad transition. An index or buffer fault shows up either as a wrong byte in the recorded write sequence or as a wrong read-back value right after done. A phase counter fault shows up as a strobe pulse that is not exactly two clocks wide.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREPOLL,
    ST_WDATA,
    ST_INSTR,
    ST_ACK,
    ST_RDATA,
    ST_DONE
  } mbs_state_e;
endpackage

// File: rtl/mbs_byte_buf.sv
module mbs_byte_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 13,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (we && (int'(waddr) == g)) begin
        mem_q[g] <= wdata;
      end
    end
  end

  assign rdata_a = (int'(raddr_a) < DEPTH) ? mem_q[raddr_a] : '0;
  assign rdata_b = (int'(raddr_b) < DEPTH) ? mem_q[raddr_b] : '0;
endmodule

// File: rtl/mbs_phase_gen.sv
module mbs_phase_gen #(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic strb_low,
  output logic sample_pt,
  output logic slot_end
);
  localparam int SLOT = LO_CYC + HI_CYC;
  localparam int PW   = (SLOT > 1) ? $clog2(SLOT) : 1;

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!en || slot_end) ph_d = '0;
    else                 ph_d = ph_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign strb_low  = en && (int'(ph_q) < LO_CYC);
  assign sample_pt = en && (int'(ph_q) == LO_CYC - 1);
  assign slot_end  = en && (int'(ph_q) == SLOT - 1);
endmodule

// File: rtl/mbs_seq.sv
module mbs_seq
  import mbs_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 13,
  parameter int CW   = 8,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_read,
  input  logic          cmd_poll_first,
  input  logic [DW-1:0] cmd_instr,
  input  logic [CW-1:0] cmd_count,
  output logic          done,
  input  logic          buf_wr_en,
  input  logic [AW-1:0] buf_wr_addr,
  input  logic [DW-1:0] buf_wr_data,
  input  logic [AW-1:0] buf_rd_addr,
  output logic [DW-1:0] buf_rd_data,
  output logic          bus_strb_n,
  output logic          bus_rnw,
  output logic          bus_dnc,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din
);
  localparam int NW   = $clog2(NREG + 1);
  localparam int ACKB = DW - 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  mbs_state_e    state_q, state_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [NW-1:0] cnt_q, cnt_clamped;
  logic          read_q;
  logic [DW-1:0] instr_q;
  logic          ack_q;
  logic          load_cmd;
  logic          active, strb_low, sample_pt, slot_end;
  logic          poll_sample, seq_we, host_we, last_idx;
  logic [DW-1:0] buf_byte;

  function automatic mbs_state_e first_access(logic rd, logic [NW-1:0] n);
    return (rd || (n == '0)) ? ST_INSTR : ST_WDATA;
  endfunction

  always_comb begin
    if (cmd_count > CW'(NREG)) cnt_clamped = NW'(NREG);
    else                       cnt_clamped = NW'(cmd_count);
  end

  assign active = (state_q == ST_PREPOLL) || (state_q == ST_WDATA) ||
                  (state_q == ST_INSTR)   || (state_q == ST_ACK)   ||
                  (state_q == ST_RDATA);

  mbs_phase_gen #(.LO_CYC(2), .HI_CYC(2)) i_phase (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .en       (active),
    .strb_low (strb_low),
    .sample_pt(sample_pt),
    .slot_end (slot_end)
  );

  assign last_idx = (NW'(idx_q) == cnt_q - NW'(1));

  // next-state process
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    load_cmd = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          load_cmd = 1'b1;
          idx_d    = '0;
          state_d  = cmd_poll_first ? ST_PREPOLL : first_access(cmd_read, cnt_clamped);
        end
      end
      ST_PREPOLL: begin
        if (slot_end && ack_q) state_d = first_access(read_q, cnt_q);
      end
      ST_WDATA: begin
        if (slot_end) begin
          if (last_idx) state_d = ST_INSTR;
          else          idx_d   = idx_q + AW'(1);
        end
      end
      ST_INSTR: begin
        if (slot_end) state_d = ST_ACK;
      end
      ST_ACK: begin
        if (slot_end && ack_q) begin
          idx_d   = '0;
          state_d = (read_q && (cnt_q != '0)) ? ST_RDATA : ST_DONE;
        end
      end
      ST_RDATA: begin
        if (slot_end) begin
          if (last_idx) state_d = ST_DONE;
          else          idx_d   = idx_q + AW'(1);
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign poll_sample = sample_pt && ((state_q == ST_PREPOLL) || (state_q == ST_ACK));

  // register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      read_q  <= 1'b0;
      instr_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (load_cmd) begin
        cnt_q   <= cnt_clamped;
        read_q  <= cmd_read;
        instr_q <= cmd_instr;
      end
      if (poll_sample) ack_q <= bus_din[ACKB];
    end
  end

  // byte buffer: sequencer read-back has priority over host writes
  assign seq_we  = (state_q == ST_RDATA) && sample_pt;
  assign host_we = buf_wr_en && (int'(buf_wr_addr) < NREG);

  mbs_byte_buf #(.DW(DW), .DEPTH(NREG), .AW(AW)) i_buf (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .we     (seq_we || host_we),
    .waddr  (seq_we ? idx_q : buf_wr_addr),
    .wdata  (seq_we ? bus_din : buf_wr_data),
    .raddr_a(buf_rd_addr),
    .rdata_a(buf_rd_data),
    .raddr_b(idx_q),
    .rdata_b(buf_byte)
  );

  // bus pins
  logic wr_phase;
  assign wr_phase   = (state_q == ST_WDATA) || (state_q == ST_INSTR);
  assign bus_strb_n = ~strb_low;
  assign bus_rnw    = ~wr_phase;
  assign bus_oe     = wr_phase;
  assign bus_dnc    = (state_q == ST_WDATA) || (state_q == ST_RDATA);
  assign bus_dout   = (state_q == ST_WDATA) ? buf_byte :
                      (state_q == ST_INSTR) ? instr_q : '0;

  assign cmd_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/mbs_seq_chk.sv
module mbs_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_strb_n,
  input logic          bus_rnw,
  input logic          bus_dnc,
  input logic [DW-1:0] bus_dout,
  input logic          bus_oe,
  input logic [DW-1:0] bus_din,
  input logic          cmd_ready,
  input logic          done
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (!bus_strb_n && !bus_rnw && !bus_dnc) begin
      pend_q <= 1'b1;
    end else if (!bus_strb_n && bus_rnw && !bus_dnc && bus_din[DW-1]) begin
      pend_q <= 1'b0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (bus_strb_n && bus_rnw && !bus_oe));

  assert_strobe_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_strb_n) |=> !bus_strb_n);

  assert_strobe_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_strb_n) |=> bus_strb_n);

  assert_no_write_before_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && $fell(bus_strb_n)) |-> bus_rnw);

  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pend_q);

  assert_hold_after_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bus_rnw) || !$stable(bus_dnc) || !$stable(bus_dout))
      |-> ($past(bus_strb_n, 1) && $past(bus_strb_n, 2)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
endmodule

bind mbs_seq mbs_seq_chk #(.DW(DW)) i_mbs_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_strb_n(bus_strb_n),
  .bus_rnw   (bus_rnw),
  .bus_dnc   (bus_dnc),
  .bus_dout  (bus_dout),
  .bus_oe    (bus_oe),
  .bus_din   (bus_din),
  .cmd_ready (cmd_ready),
  .done      (done)
);

// File: tb/test_mbs_seq.sv
module test_mbs_seq;
  localparam int DW = 8, NREG = 13, CW = 8, AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_ready, cmd_read = 1'b0, cmd_poll_first = 1'b0;
  logic [DW-1:0] cmd_instr = '0;
  logic [CW-1:0] cmd_count = '0;
  logic          done;
  logic          buf_wr_en = 1'b0;
  logic [AW-1:0] buf_wr_addr = '0, buf_rd_addr = '0;
  logic [DW-1:0] buf_wr_data = '0, buf_rd_data;
  logic          bus_strb_n, bus_rnw, bus_dnc, bus_oe;
  logic [DW-1:0] bus_dout, bus_din;

  mbs_seq i_mbs_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_poll_first(cmd_poll_first), .cmd_instr(cmd_instr), .cmd_count(cmd_count),
    .done(done),
    .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .bus_strb_n(bus_strb_n), .bus_rnw(bus_rnw), .bus_dnc(bus_dnc),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  int checks = 0, errors = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // controller model
  int         stat_cnt = 0, ack_set = 0, ptr = 0;
  logic [7:0] sregs [NREG];
  assign bus_din = (!bus_strb_n && bus_rnw) ?
                   (bus_dnc ? ((ptr < NREG) ? sregs[ptr] : 8'h00) : {(stat_cnt == 0), 7'h15}) :
                   8'h00;

  // slot monitor
  bit         prev_strb = 1'b1;
  int         low_run = 0, high_run = 100;
  int         strb_err = 0, stab_err = 0, tri_err = 0, done_cnt = 0, log_n = 0;
  logic [9:0] cap = '0, cur;
  logic [9:0] log_q [64];

  always @(negedge clk) begin
    if (rst_n) begin
      cur = {bus_rnw, bus_dnc, bus_rnw ? 8'h00 : bus_dout};
      if (bus_oe !== !bus_rnw) tri_err++;
      if (done) done_cnt++;
      if (!bus_strb_n) begin
        if (prev_strb) begin
          cap = cur; low_run = 1;
          if (high_run < 2) strb_err++;
        end else begin
          low_run++;
          if (cur !== cap) stab_err++;
        end
      end else begin
        if (!prev_strb) begin
          if (low_run != 2) strb_err++;
          if (cur !== cap) stab_err++;
          if (log_n < 64) begin log_q[log_n] = cap; log_n++; end
          high_run = 1;
          if (cap[9] && !cap[8]) begin
            if (stat_cnt > 0) stat_cnt--;
          end else if (!cap[9] && !cap[8]) begin
            stat_cnt = ack_set; ptr = 0;
          end else begin
            ptr++;
          end
        end else begin
          high_run++;
          if (high_run == 2 && cur !== cap) stab_err++;
        end
      end
      prev_strb = bus_strb_n;
    end
  end

  task automatic run_cmd(bit rd, bit poll, logic [7:0] instr, int count, int pre,
                         int ackd, bit spurious, string tag);
    logic [7:0] wbytes [NREG];
    logic [9:0] exp_q [64];
    int en = 0;
    int n;
    int bad = -1;
    n = (count > NREG) ? NREG : count;
    for (int i = 0; i < NREG; i++) begin
      wbytes[i] = 8'($urandom);
      sregs[i]  = 8'($urandom);
    end
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk);
      buf_wr_en = 1'b1; buf_wr_addr = AW'(i); buf_wr_data = wbytes[i];
    end
    @(negedge clk);
    buf_wr_en = 1'b0;
    stat_cnt = pre; ack_set = ackd; log_n = 0; done_cnt = 0;
    if (poll) for (int i = 0; i <= pre; i++) begin exp_q[en] = {2'b10, 8'h00}; en++; end
    if (!rd)  for (int i = 0; i < n; i++)   begin exp_q[en] = {2'b01, wbytes[i]}; en++; end
    exp_q[en] = {2'b00, instr}; en++;
    for (int i = 0; i <= ackd; i++) begin exp_q[en] = {2'b10, 8'h00}; en++; end
    if (rd)   for (int i = 0; i < n; i++)   begin exp_q[en] = {2'b11, 8'h00}; en++; end

    check(cmd_ready === 1'b1, "R10", "ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_read = rd; cmd_poll_first = poll;
    cmd_instr = instr; cmd_count = CW'(count);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (spurious) begin
      repeat (3) @(negedge clk);
      cmd_valid = 1'b1; cmd_read = ~rd; cmd_instr = ~instr; cmd_count = 8'd5; cmd_poll_first = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (30) @(negedge clk);

    check(log_n == en, tag, "bus access count", log_n, en);
    for (int i = 0; i < en && i < log_n; i++)
      if (bad < 0 && log_q[i] !== exp_q[i]) bad = i;
    check(bad < 0, tag, "bus access sequence {rnw,dnc,byte}",
          (bad < 0) ? 0 : log_q[bad], (bad < 0) ? 0 : exp_q[bad]);
    check(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    if (rd) begin
      for (int i = 0; i < NREG; i++) begin
        buf_rd_addr = AW'(i);
        #0.5;
        if (i < n) check(buf_rd_data == sregs[i], "R7", "read-back byte", buf_rd_data, sregs[i]);
        else       check(buf_rd_data == wbytes[i], "R5", "untouched entry", buf_rd_data, wbytes[i]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1207);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bus_strb_n === 1'b1, "R1", "strobe after reset", bus_strb_n, 1);
    check(bus_rnw === 1'b1, "R1", "rnw after reset", bus_rnw, 1);
    check(bus_oe === 1'b0, "R1", "oe after reset", bus_oe, 0);
    check(cmd_ready === 1'b1 && done === 1'b0, "R1", "ready/done after reset", {cmd_ready, done}, 2);

    run_cmd(1'b0, 1'b0, 8'h41, 3,   0, 0,  1'b0, "R4");
    run_cmd(1'b0, 1'b0, 8'h42, 0,   0, 2,  1'b0, "R5");
    run_cmd(1'b0, 1'b1, 8'h43, 13,  3, 1,  1'b0, "R8");
    run_cmd(1'b0, 1'b0, 8'h44, 200, 0, 0,  1'b0, "R5");
    run_cmd(1'b1, 1'b0, 8'h85, 5,   0, 25, 1'b0, "R6");
    run_cmd(1'b1, 1'b0, 8'h86, 0,   0, 1,  1'b0, "R5");
    run_cmd(1'b1, 1'b1, 8'h87, 13,  2, 3,  1'b1, "R10");
    run_cmd(1'b0, 1'b0, 8'h48, 2,   0, 4,  1'b1, "R10");

    for (int k = 0; k < 25; k++) begin
      run_cmd(1'($urandom), 1'($urandom), 8'($urandom), int'($urandom % 20),
              int'($urandom % 6), int'($urandom % 12), 1'b0, "R7");
    end

    check(strb_err == 0, "R2", "strobe width violations", strb_err, 0);
    check(tri_err == 0, "R3", "output enable vs rnw mismatches", tri_err, 0);
    check(stab_err == 0, "R9", "control/data changes inside hold window", stab_err, 0);
    summary();
    $finish;
  end
endmodule